// File: doc/BRIEF.md
# Lock Qualifier and Output Mute

This block sits behind a clock-and-data recovery loop and decides whether the recovered bit stream can be trusted. It runs on the sample clock. On each bit-valid strobe it takes the retimed bit. It keeps two watchdogs. The first watches for level changes between consecutive bits and shows that data is arriving. The second watches for an isolated bit, meaning a bit that differs from both of its neighbours. Such a bit cannot appear when the loop runs at twice the data rate and every bit is sampled twice.

The lock flag is the registered AND of three inputs: the data-present watchdog, the isolated-bit watchdog and the phase-lock status from the loop. While the flag is low, the serial data output freezes at its last value and does not pass noise through. The first valid bit after the flag rises goes straight to the output. The recovered clock is not gated by this block, so it keeps running. Both timeouts are parameters. The data-present window is counted in sample clocks. The isolated-bit window is counted in system ticks.

Top module: `lock_qual`

## Requirements
- R1: `lock_o` is high in a cycle only if, at the previous clock edge, `phase_lock_i`, the data-present flag and the harmonic-ok flag were all high. It rises one clock after all three are high and falls one clock after any one of them drops.
- R2: A transition is a valid bit that differs from the previous valid bit. Each transition reloads the data-present counter with ACT_LIM, and the counter counts down on every clock. `present_o` is high while the counter is nonzero, so it falls exactly ACT_LIM clocks after the last transition.
- R3: An isolated bit is three consecutive valid bits forming 1,0,1 or 0,1,0. Each one reloads the harmonic counter with HARM_LIM, and the counter counts down only on clocks where `sys_tick_i` is high. `harm_ok_o` is high while that counter is nonzero.
- R4: A stream in which every bit is repeated (0,0,1,1,...) keeps `present_o` high but drives `harm_ok_o` low, and therefore `lock_o` low.
- R5: While `lock_o` is low, `data_o` does not change, even if `data_i` toggles.
- R6: On the first clock edge where `lock_o` is already high and `bit_vld_i` is high, `data_o` takes `data_i`. After that it follows each valid bit with one clock of latency.
- R7: When `bit_vld_i` is low, `data_i` is ignored. It starts no transition, no isolated bit and no output update, so toggling it leaves `present_o` free to time out.
- R8: After reset all outputs are 0 and the bit history is empty. The first transition needs two valid bits after reset.
- R9: A gap of up to ACT_LIM clocks between transitions keeps `present_o` and `lock_o` high without interruption. This includes a transition that arrives on the exact clock the counter would otherwise expire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | Retimed data bit |
| bit_vld_i | input | 1 | Strobe marking `data_i` as a new bit |
| phase_lock_i | input | 1 | Phase-lock status from the loop |
| sys_tick_i | input | 1 | Slow system tick, one-clock pulse |
| lock_o | output | 1 | Qualified lock flag |
| present_o | output | 1 | Input data detected |
| harm_ok_o | output | 1 | Isolated bits seen recently (not harmonic) |
| data_o | output | 1 | Muted serial data |

## Verification
Two things can land on the same clock edge, and the bench forces each case. In the first, a transition arrives on exactly the edge where the data-present counter would reach zero; the reload must win. The bench toggles the data every ACT_LIM clocks and requires `present_o` to stay high at every sample. In the second, `lock_o` rises while a valid bit is present. That bit must not pass through on the same edge. It must reach `data_o` on the following edge. The bench checks the frozen value on the edge where lock returns and the new bit one edge later.

// File: rtl/lock_qual_pkg.sv
package lock_qual_pkg;
  // last two valid bits (b[0] newest) and how many are filled
  typedef struct packed {
    logic [1:0] b;
    logic [1:0] depth;
  } bit_hist_t;
endpackage

// File: rtl/lq_bit_events.sv
module lq_bit_events
  import lock_qual_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  input  logic vld_i,
  output logic trans_o,
  output logic iso_o
);
  bit_hist_t hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
    end else if (vld_i) begin
      hist_q.b <= {hist_q.b[0], data_i};
      if (hist_q.depth != 2'd2) hist_q.depth <= hist_q.depth + 2'd1;
    end
  end

  always_comb begin
    trans_o = vld_i && (hist_q.depth != 2'd0) && (data_i != hist_q.b[0]);
    iso_o   = vld_i && (hist_q.depth == 2'd2) &&
              (data_i == hist_q.b[1]) && (data_i != hist_q.b[0]);
  end

  // R7: no event without a valid strobe
  a_r7_evt_needs_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trans_o || iso_o) |-> vld_i);
  // R3: an isolated bit is always also a transition
  a_r3_iso_is_trans: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iso_o |-> trans_o);
endmodule

// File: rtl/lq_watchdog.sv
module lq_watchdog #(
  parameter int LIM = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic dec_i,
  output logic ok_o
);
  localparam int W = $clog2(LIM + 1);
  localparam logic [W-1:0] LOAD = W'(LIM);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (evt_i)                   cnt_q <= LOAD;   // reload wins over expiry
    else if (dec_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign ok_o = (cnt_q != '0);

  // R2/R3: event always leaves flag set
  a_r2_reload_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> ok_o);
  // R3: no spontaneous revival
  a_r3_stays_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ok_o && !evt_i) |=> !ok_o);
  // R3: counter only moves down when allowed
  a_r3_hold_no_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i && !dec_i) |=> $stable(cnt_q));
endmodule

// File: rtl/lq_mute.sv
module lq_mute (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic vld_i,
  input  logic data_i,
  output logic data_o
);
  logic data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               data_q <= 1'b0;
    else if (lock_i && vld_i)  data_q <= data_i;
  end

  assign data_o = data_q;

  // R5: frozen while unlocked
  a_r5_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> $stable(data_o));
endmodule

// File: rtl/lock_qual.sv
module lock_qual #(
  parameter int ACT_LIM  = 32,
  parameter int HARM_LIM = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  input  logic bit_vld_i,
  input  logic phase_lock_i,
  input  logic sys_tick_i,
  output logic lock_o,
  output logic present_o,
  output logic harm_ok_o,
  output logic data_o
);
  logic trans_evt, iso_evt, act_ok, harm_ok, lock_q;

  lq_bit_events u_evt (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .vld_i(bit_vld_i),
    .trans_o(trans_evt), .iso_o(iso_evt)
  );

  lq_watchdog #(.LIM(ACT_LIM)) u_act (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(trans_evt), .dec_i(1'b1), .ok_o(act_ok)
  );

  lq_watchdog #(.LIM(HARM_LIM)) u_harm (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(iso_evt), .dec_i(sys_tick_i), .ok_o(harm_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else         lock_q <= act_ok && harm_ok && phase_lock_i;
  end

  lq_mute u_mute (
    .clk_i(clk_i), .rst_ni(rst_ni), .lock_i(lock_q), .vld_i(bit_vld_i),
    .data_i(data_i), .data_o(data_o)
  );

  assign lock_o    = lock_q;
  assign present_o = act_ok;
  assign harm_ok_o = harm_ok;

  // R1: lock needs phase lock one cycle earlier
  a_r1_needs_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> $past(phase_lock_i));
  // R1: losing data presence drops lock next cycle
  a_r1_drop_on_absent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !present_o |=> !lock_o);
  // R4: harmonic flag low drops lock next cycle
  a_r4_drop_on_harm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !harm_ok_o |=> !lock_o);
endmodule

// File: tb/sim_lock_qual.sv
module sim_lock_qual;
  localparam int ACT = 8;
  localparam int HRM = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic d = 1'b0, vld = 1'b0, pl = 1'b0, tick = 1'b0;
  logic lock, pres, hok, dout;
  int n_chk = 0, n_bad = 0;
  int ph = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  lock_qual #(.ACT_LIM(ACT), .HARM_LIM(HRM)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .data_i(d), .bit_vld_i(vld),
    .phase_lock_i(pl), .sys_tick_i(tick), .lock_o(lock),
    .present_o(pres), .harm_ok_o(hok), .data_o(dout)
  );

  // system tick every 4 clocks
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      tick = (c % 4 == 3);
      c++;
    end
  end

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // drive one cycle, sample after the edge
  task automatic step(input logic b, input logic v, input logic p);
    @(negedge clk);
    d = b; vld = v; pl = p;
    @(posedge clk);
    #1;
  endtask

  // mode: 0 alternating, 1 doubled, 2 constant
  function automatic logic gen(input int mode, input int k, input logic last);
    case (mode)
      0: return logic'(k % 2);
      1: return logic'((k / 2) % 2);
      default: return last;
    endcase
  endfunction

  // {mode[1:0], pl, exp_present, exp_harm, exp_lock}
  localparam logic [5:0] VEC [9] = '{
    6'b00_1_111, 6'b01_1_100, 6'b00_1_111, 6'b10_1_000, 6'b00_0_110,
    6'b00_1_111, 6'b01_0_100, 6'b10_0_000, 6'b00_1_111
  };

  initial begin
    logic ref_b;
    // R8 reset state
    #1;
    chk(lock, 1'b0, "R8 lock"); chk(pres, 1'b0, "R8 present");
    chk(hok, 1'b0, "R8 harm"); chk(dout, 1'b0, "R8 data");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b1, 1'b0);
    chk(pres, 1'b0, "R8 single bit no transition");
    step(1'b0, 1'b1, 1'b0);
    chk(pres, 1'b1, "R8 second bit transition");

    // table walk
    for (int v = 0; v < 9; v++) begin
      for (int k = 0; k < 40; k++) begin
        step(gen(int'(VEC[v][5:4]), ph, d), 1'b1, VEC[v][3]);
        ph++;
      end
      chk(pres, VEC[v][2], $sformatf("R2 vec%0d present", v));
      chk(hok,  VEC[v][1], $sformatf("R3 R4 vec%0d harm", v));
      chk(lock, VEC[v][0], $sformatf("R1 vec%0d lock", v));
      if (VEC[v][0]) chk(dout, d, $sformatf("R6 vec%0d data follows", v));
    end
    // ends locked on alternating data

    // R9 short gap: hold ACT-1 extra cycles then toggle
    begin
      logic ok = 1'b1;
      ref_b = d;
      for (int k = 0; k < ACT - 1; k++) begin
        step(ref_b, 1'b1, 1'b1);
        if (!lock || !pres) ok = 1'b0;
      end
      step(~ref_b, 1'b1, 1'b1);
      if (!lock || !pres) ok = 1'b0;
      chk(ok, 1'b1, "R9 short gap keeps lock");
    end

    // R9 transitions exactly ACT apart
    begin
      logic ok = 1'b1;
      for (int k = 0; k < 5 * ACT; k++) begin
        step((k % ACT == 0) ? ~d : d, 1'b1, 1'b1);
        if (!pres) ok = 1'b0;
      end
      chk(ok, 1'b1, "R9 reload on expiry edge");
    end

    // relock on alternating data
    for (int k = 0; k < 30; k++) step(logic'(k % 2), 1'b1, 1'b1);
    chk(lock, 1'b1, "R1 relock");

    // R2 exact expiry after last transition
    step(~d, 1'b1, 1'b1);   // transition at edge e
    ref_b = d;
    for (int j = 1; j <= ACT + 1; j++) begin
      step(ref_b, 1'b1, 1'b1);
      if (j == ACT - 1) chk(pres, 1'b1, "R2 present before expiry");
      if (j == ACT)     begin chk(pres, 1'b0, "R2 present at expiry"); chk(lock, 1'b1, "R1 lock lags one cycle"); end
      if (j == ACT + 1) chk(lock, 1'b0, "R1 lock drops");
    end

    // relock, then R5 mute by phase loss
    for (int k = 0; k < 30; k++) step(logic'(k % 2), 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b0);          // pl drop: last bit still passes
    chk(lock, 1'b0, "R1 phase loss");
    chk(dout, 1'b1, "R5 last bit before mute");
    for (int k = 0; k < 10; k++) step(logic'(k % 2), 1'b1, 1'b0);
    chk(dout, 1'b1, "R5 frozen while unlocked");
    // R6 unmute timing
    step(1'b0, 1'b1, 1'b1);
    chk(lock, 1'b1, "R6 lock back");
    chk(dout, 1'b1, "R6 no pass on lock edge");
    step(1'b1, 1'b0, 1'b1);
    chk(dout, 1'b1, "R7 invalid bit not passed");
    step(1'b0, 1'b1, 1'b1);
    chk(dout, 1'b0, "R6 first valid bit passes");

    // R7 toggling with strobe low: presence expires
    for (int k = 0; k < ACT + 4; k++) step(logic'(k % 2), 1'b0, 1'b1);
    chk(pres, 1'b0, "R7 ignored toggles");
    chk(lock, 1'b0, "R7 lock lost");

    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule